// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Unit

This unit gathers one-cycle event pulses from the surrounding MAC and holds each one as a sticky flag in an 8-bit status register. The pulses come from the transmit state machine, the PHY management engine and the receive path. Software reads the flags and clears them by writing ones. A second 8-bit register with the same bit layout enables the flags one by one. Two interrupt lines are driven from the enabled flags: one for receive events and one for system events.

The unit also keeps frames out after a receive overrun. While the overrun flag is set, the receive path is told to discard every incoming frame. If the flag is cleared in the middle of a frame, that frame is still discarded to its end, and acceptance resumes at the next frame start.

The transmit fault flag is exported to the transmit-path reset logic. It stays set until software clears it or the transmit path is reset.

Top module: `mac_irq_status`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_rx`, `irq_sys`, `rx_block` and `tx_err` are low.
- R2: The status flags sit at these bit positions: bit 7 transmit FSM fault (`ev_tx_fsm_err`), bit 6 management access done (`ev_mgmt_done`), bit 5 receive control frame (`ev_rx_ctrl`), bit 4 receive pause frame (`ev_rx_pause`), bit 3 receive done (`ev_rx_done`), bit 2 receive overrun (`ev_rx_overrun`). An event pulse sets its flag at the next clock edge, and the flag stays set without further events.
- R3: A write with `cpu_sel`=0 clears every status bit whose `cpu_wdata` bit is 1 at the next edge. Bits written with 0 keep their value.
- R4: When an event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: Bits 1 and 0 of both registers always read 0, and writes to them have no effect.
- R6: A write with `cpu_sel`=1 loads the enable register (same bit layout as the status register). `cpu_rdata` shows the enable register when `cpu_sel`=1 and the status register when `cpu_sel`=0, with no clock delay.
- R7: `irq_rx` is the OR of status bits 5, 4 and 3, each ANDed with its enable bit.
- R8: `irq_sys` is the OR of status bits 7, 6 and 2, each ANDed with its enable bit.
- R9: `rx_block` is high in every cycle in which the overrun flag (bit 2) is set.
- R10: A frame that is in progress (after `rx_sof`, up to and including `rx_eof`) when the overrun flag is set keeps `rx_block` high until that frame's `rx_eof`, even if the flag is cleared earlier. Acceptance (`rx_block` low) resumes after that end. A frame that starts while the flag is set is blocked the same way.
- R11: `tx_err` follows status bit 7. A pulse on `tx_path_rst` clears bit 7 at the next edge and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register select: 0 status, 1 enable |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| ev_tx_fsm_err | input | 1 | Transmit FSM fault pulse |
| ev_mgmt_done | input | 1 | PHY management access completed pulse |
| ev_rx_ctrl | input | 1 | Control frame received pulse |
| ev_rx_pause | input | 1 | Pause frame received pulse |
| ev_rx_done | input | 1 | Frame reception done pulse |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| tx_path_rst | input | 1 | Transmit-path reset, clears the fault flag |
| rx_sof | input | 1 | Incoming frame start pulse |
| rx_eof | input | 1 | Incoming frame end pulse |
| rx_block | output | 1 | Discard the incoming frame |
| irq_rx | output | 1 | Receive interrupt |
| irq_sys | output | 1 | System interrupt |
| tx_err | output | 1 | Transmit fault condition to the transmit path |

## Verification
The hardest case to reach is an overrun flag that is cleared while a frame is still arriving. The bench opens a frame with `rx_sof`, fires the overrun pulse in the middle of it, and clears the flag before `rx_eof`. It then checks that `rx_block` stays high up to the end of the frame and drops afterwards. It also starts a new frame while the flag is still set, to check that this frame is blocked too. The set-over-clear race is reached by firing an event pulse in the same cycle as a write-one clear of its own bit.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    localparam int REG_W     = 8;
    localparam int B_TXERR   = 7;
    localparam int B_MGMT    = 6;
    localparam int B_RXCTRL  = 5;
    localparam int B_RXPAUSE = 4;
    localparam int B_RXDONE  = 3;
    localparam int B_RXOVR   = 2;
    localparam logic [REG_W-1:0] IMPL_MASK = 8'hFC;
    localparam logic [REG_W-1:0] RX_MASK   = (1 << B_RXCTRL) | (1 << B_RXPAUSE) | (1 << B_RXDONE);
    localparam logic [REG_W-1:0] SYS_MASK  = (1 << B_TXERR) | (1 << B_MGMT) | (1 << B_RXOVR);

    typedef struct packed {
        logic [REG_W-1:0] stat;
    } flag_state_t;

    typedef struct packed {
        logic [REG_W-1:0] en;
    } mask_state_t;

    typedef struct packed {
        logic drop;
    } gate_state_t;
endpackage

// File: rtl/mac_irq_flags.sv
module mac_irq_flags
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_ev,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] clr_data,
    input  logic             txp_rst,
    output logic [REG_W-1:0] stat_q
);
    flag_state_t st_d, st_q;
    logic [REG_W-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_wr ? clr_data : '0;
        if (txp_rst) clr_mask[B_TXERR] = 1'b1;
        st_d.stat = ((st_q.stat & ~clr_mask) | set_ev) & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask)));
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stat_q & $past(clr_data & ~set_ev)) == '0));
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_ev & IMPL_MASK)) |=> ((stat_q & $past(set_ev & IMPL_MASK)) == $past(set_ev & IMPL_MASK)));
    assert_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/mac_irq_mask.sv
module mac_irq_mask
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_data,
    input  logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] en_q,
    output logic             irq_rx,
    output logic             irq_sys
);
    mask_state_t ms_d, ms_q;
    logic [REG_W-1:0] live;

    always_comb begin
        ms_d = ms_q;
        if (en_wr) ms_d.en = en_data & IMPL_MASK;
        live    = stat & ms_q.en;
        irq_rx  = |(live & RX_MASK);
        irq_sys = |(live & SYS_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ms_q <= '0;
        else        ms_q <= ms_d;
    end

    assign en_q = ms_q.en;

    assert_rx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en_q & RX_MASK) == '0) |-> !irq_rx);
    assert_sys_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en_q & SYS_MASK) == '0) |-> !irq_sys);
    assert_en_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q == ($past(en_data) & IMPL_MASK)));
endmodule

// File: rtl/mac_rx_gate.sv
module mac_rx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_flag,
    input  logic sof,
    input  logic eof,
    output logic block
);
    import mac_irq_pkg::*;
    gate_state_t gs_d, gs_q;

    always_comb begin
        gs_d = gs_q;
        if (sof)      gs_d.drop = ovr_flag;
        else if (eof) gs_d.drop = 1'b0;
        else          gs_d.drop = gs_q.drop | ovr_flag;
        block = ovr_flag | gs_q.drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gs_q <= '0;
        else        gs_q <= gs_d;
    end

    assert_block_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |-> block);
    assert_hold_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (block && !sof && !eof) |=> block);
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             ev_tx_fsm_err,
    input  logic             ev_mgmt_done,
    input  logic             ev_rx_ctrl,
    input  logic             ev_rx_pause,
    input  logic             ev_rx_done,
    input  logic             ev_rx_overrun,
    input  logic             tx_path_rst,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             rx_block,
    output logic             irq_rx,
    output logic             irq_sys,
    output logic             tx_err
);
    logic [REG_W-1:0] set_ev, stat, en;

    always_comb begin
        set_ev            = '0;
        set_ev[B_TXERR]   = ev_tx_fsm_err;
        set_ev[B_MGMT]    = ev_mgmt_done;
        set_ev[B_RXCTRL]  = ev_rx_ctrl;
        set_ev[B_RXPAUSE] = ev_rx_pause;
        set_ev[B_RXDONE]  = ev_rx_done;
        set_ev[B_RXOVR]   = ev_rx_overrun;
    end

    mac_irq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .clr_wr   (cpu_wr && !cpu_sel),
        .clr_data (cpu_wdata),
        .txp_rst  (tx_path_rst),
        .stat_q   (stat)
    );

    mac_irq_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (cpu_wr && cpu_sel),
        .en_data (cpu_wdata),
        .stat    (stat),
        .en_q    (en),
        .irq_rx  (irq_rx),
        .irq_sys (irq_sys)
    );

    mac_rx_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_flag (stat[B_RXOVR]),
        .sof      (rx_sof),
        .eof      (rx_eof),
        .block    (rx_block)
    );

    assign cpu_rdata = cpu_sel ? en : stat;
    assign tx_err    = stat[B_TXERR];

    assert_txrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_path_rst && !ev_tx_fsm_err) |=> !tx_err);
endmodule

// File: tb/tb_mac_irq_status.sv
module tb_mac_irq_status;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic ev_tx_fsm_err = 0, ev_mgmt_done = 0, ev_rx_ctrl = 0, ev_rx_pause = 0;
    logic ev_rx_done = 0, ev_rx_overrun = 0, tx_path_rst = 0, rx_sof = 0, rx_eof = 0;
    logic rx_block, irq_rx, irq_sys, tx_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_irq_status dut (.*);

    typedef struct {
        logic       sel;
        logic [7:0] rdata;
        logic       irx, isys, blk, terr;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int tests = 0, fails = 0;
    bit done = 0;

    // bench model of the registers, from the requirements
    logic [7:0] m_stat = 0, m_en = 0;
    logic       m_drop = 0;

    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            tests++;
            if (cpu_rdata !== e.rdata) begin fails++; $display("FAIL %s rdata sel=%0d got %02h exp %02h", e.tag, e.sel, cpu_rdata, e.rdata); end
            if (irq_rx !== e.irx)      begin fails++; $display("FAIL %s irq_rx got %0b exp %0b", e.tag, irq_rx, e.irx); end
            if (irq_sys !== e.isys)    begin fails++; $display("FAIL %s irq_sys got %0b exp %0b", e.tag, irq_sys, e.isys); end
            if (rx_block !== e.blk)    begin fails++; $display("FAIL %s rx_block got %0b exp %0b", e.tag, rx_block, e.blk); end
            if (tx_err !== e.terr)     begin fails++; $display("FAIL %s tx_err got %0b exp %0b", e.tag, tx_err, e.terr); end
        end
    end

    task automatic expect_now(input logic sel, input string tag);
        exp_t e;
        logic [7:0] live;
        cpu_sel = sel;
        live    = m_stat & m_en;
        e.sel   = sel;
        e.rdata = sel ? m_en : m_stat;
        e.irx   = |(live & 8'h38);
        e.isys  = |(live & 8'hC4);
        e.blk   = m_stat[2] | m_drop;
        e.terr  = m_stat[7];
        e.tag   = tag;
        sbq.push_back(e);
        wait (sbq.size() == 0);
    endtask

    // one clock cycle of stimulus; ev bits use the status bit layout
    task automatic step(input logic [7:0] ev, input logic wr, input logic sel,
                        input logic [7:0] wd, input logic txr, input logic sof, input logic eof);
        logic [7:0] clr;
        cpu_wr = wr; cpu_sel = sel; cpu_wdata = wd; tx_path_rst = txr;
        rx_sof = sof; rx_eof = eof;
        ev_tx_fsm_err = ev[7]; ev_mgmt_done = ev[6]; ev_rx_ctrl = ev[5];
        ev_rx_pause = ev[4]; ev_rx_done = ev[3]; ev_rx_overrun = ev[2];
        @(posedge clk);
        #1;
        if (sof)      m_drop = m_stat[2];
        else if (eof) m_drop = 1'b0;
        else          m_drop = m_drop | m_stat[2];
        clr = (wr && !sel) ? wd : 8'h00;
        if (txr) clr[7] = 1'b1;
        m_stat = ((m_stat & ~clr) | ev) & 8'hFC;
        if (wr && sel) m_en = wd & 8'hFC;
        cpu_wr = 0; tx_path_rst = 0; rx_sof = 0; rx_eof = 0;
        {ev_tx_fsm_err, ev_mgmt_done, ev_rx_ctrl, ev_rx_pause, ev_rx_done, ev_rx_overrun} = '0;
    endtask

    task automatic idle();
        step(8'h00, 0, 0, 8'h00, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_now(0, "R1 status after reset");
        expect_now(1, "R1 enable after reset");

        // R2: each event sets its own bit and sticks
        for (int b = 2; b < 8; b++) begin
            step(8'h01 << b, 0, 0, 0, 0, 0, 0);
            expect_now(0, "R2 event sets bit");
            idle();
            expect_now(0, "R2 flag sticky");
            step(0, 1, 0, 8'hFF, 0, 0, 0);
            expect_now(0, "R3 clear all");
        end

        // R3: selective clear, zero write keeps
        step(8'h38, 0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 8'h00, 0, 0, 0);
        expect_now(0, "R3 zero write keeps flags");
        step(0, 1, 0, 8'h08, 0, 0, 0);
        expect_now(0, "R3 clears only bit 3");

        // R4: set beats clear on same bit
        step(8'h10, 1, 0, 8'h10, 0, 0, 0);
        expect_now(0, "R4 set wins over clear");

        // R5/R6: enable register and reserved bits
        step(0, 1, 1, 8'hFF, 0, 0, 0);
        expect_now(1, "R5 R6 enable reads FC");
        step(0, 1, 0, 8'h03, 0, 0, 0);
        expect_now(0, "R5 reserved status write ignored");
        step(8'h03, 0, 0, 0, 0, 0, 0);
        expect_now(0, "R5 reserved bits stay zero");

        // R7/R8: interrupt masking
        step(0, 1, 0, 8'hFF, 0, 0, 0);
        step(0, 1, 1, 8'h08, 0, 0, 0);
        step(8'h30, 0, 0, 0, 0, 0, 0);
        expect_now(0, "R7 rx flags masked");
        step(8'h08, 0, 0, 0, 0, 0, 0);
        expect_now(0, "R7 rx done enabled irq_rx");
        step(8'h40, 0, 0, 0, 0, 0, 0);
        expect_now(0, "R8 mgmt masked no irq_sys");
        step(0, 1, 1, 8'h40, 0, 0, 0);
        expect_now(1, "R8 mgmt enabled irq_sys, R7 rx off");
        step(0, 1, 0, 8'hFF, 0, 0, 0);
        expect_now(0, "R8 irq_sys drops after clear");

        // R9/R10: overrun mid-frame, cleared mid-frame
        step(0, 1, 1, 8'h04, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        expect_now(0, "R10 frame accepted before overrun");
        step(8'h04, 0, 0, 0, 0, 0, 0);
        expect_now(0, "R9 overrun blocks, irq_sys");
        step(0, 1, 0, 8'h04, 0, 0, 0);
        expect_now(0, "R10 cleared mid frame still blocked");
        idle();
        expect_now(0, "R10 still blocked in frame");
        step(0, 0, 0, 0, 0, 0, 1);
        expect_now(0, "R10 acceptance after frame end");
        step(0, 0, 0, 0, 0, 1, 0);
        expect_now(0, "R10 next frame accepted");
        step(0, 0, 0, 0, 0, 0, 1);
        // overrun while idle, frame starts under it
        step(8'h04, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        expect_now(0, "R9 frame start under overrun blocked");
        step(0, 1, 0, 8'h04, 0, 0, 0);
        expect_now(0, "R10 frame started under overrun stays blocked");
        step(0, 0, 0, 0, 0, 0, 1);
        expect_now(0, "R10 released at frame end");

        // R11: transmit path reset clears bit 7 only
        step(8'hC8, 0, 0, 0, 0, 0, 0);
        expect_now(0, "R11 tx_err set");
        step(0, 0, 0, 0, 1, 0, 0);
        expect_now(0, "R11 tx reset clears bit 7 only");
        step(8'h80, 0, 0, 0, 1, 0, 0);
        expect_now(0, "R11 R4 fault event beats tx reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule